// File: doc/BRIEF.md
# Thread-Block Admission Controller

This block decides, one clock at a time, whether the next waiting thread block of a kernel may become resident on a single multiprocessor. A launch configuration (threads per block, registers per thread, shared-memory bytes per block, register pool size and register rounding step) is loaded while the multiprocessor is empty. From it the block derives one block's rounded demand on four pools: resident-block slots, warp slots, registers and shared memory. Running totals of what resident blocks hold are kept for each pool.

Waiting blocks are presented in arrival order on a valid/ready pair. Ready is raised only when every pool can still take one more block. A block that does not fit simply waits; nothing already resident is ever evicted or spilled. A completion pulse hands one block's resources back to all four pools at once. The block reports the resident block count and the active warp count, flags a configuration that could never fit even on an empty multiprocessor, and keeps a sticky flag for a completion pulse that arrives with nothing resident.

Top module: `blk_admit_ctrl`

## Requirements
- R1: After a synchronous active-low reset, resident_blocks and active_warps are 0, blk_ready is 0 (no configuration held), and cfg_never_fits and done_underflow are 0.
- R2: A cfg_load pulse captures the configuration inputs only when no block is resident; a pulse while any block is resident is ignored and the previous per-block demand stays in force.
- R3: At most 8 blocks are resident at once, however small their other demands.
- R4: A block takes ceil(threads/32) warp slots (50 threads take 2 warps, 64 thread slots); the warp slots of all resident blocks never exceed 48 (1536 threads).
- R5: Shared memory per block is rounded up to a multiple of 128 bytes before it is checked and reserved; the reserved total never exceeds 49152 bytes.
- R6: A block's register demand is registers per thread rounded up to the step (cfg_reg_gran8 = 0: step 4, 1: step 8) times its warp-rounded thread slots; the pool is 8192, 16384 or 32768 for cfg_reg_pool_sel 0, 1 or 2 (3 also selects 32768); the reserved total never exceeds the pool.
- R7: cfg_never_fits is 1 while the held configuration has 0 threads, more than 1024 threads, registers per thread times threads above the pool, a rounded register demand above the pool, or rounded shared memory above 49152; blk_ready then stays 0.
- R8: blk_ready is 1 exactly when a valid configuration is held and one more block fits every pool; a block is admitted on a clock edge where blk_valid and blk_ready are both 1, at most one per clock, in offer order.
- R9: A blk_done pulse while at least one block is resident releases one block's whole demand from all pools at the next edge; a waiting block that fits afterwards sees blk_ready on the following cycle; an admit and a release on the same edge leave the totals unchanged.
- R10: active_warps equals resident_blocks times the block's warp count and changes only on the edge after an admit or a release.
- R11: A blk_done pulse while no block is resident changes no total and sets done_underflow, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture the configuration inputs (only when empty) |
| cfg_threads | input | 11 | Threads per block |
| cfg_regs_per_thread | input | 8 | Registers per thread |
| cfg_smem_bytes | input | 17 | Shared-memory bytes per block |
| cfg_reg_pool_sel | input | 2 | Register pool size select |
| cfg_reg_gran8 | input | 1 | Register rounding step: 0 gives 4, 1 gives 8 |
| blk_valid | input | 1 | A block is waiting |
| blk_ready | output | 1 | The waiting block can be admitted |
| blk_done | input | 1 | One resident block completed |
| resident_blocks | output | 4 | Number of resident blocks |
| active_warps | output | 6 | Warp slots held by resident blocks |
| cfg_never_fits | output | 1 | Held configuration can never be admitted |
| done_underflow | output | 1 | Sticky: completion seen with nothing resident |

## Verification
The admission limit is tried with configurations chosen so that each of the four pools is in turn the one that stops admission: tiny blocks stop at the block cap, large blocks at warp slots, register-heavy blocks at each pool size and with each rounding step, and shared-memory blocks on either side of a 128-byte boundary. Pairs that differ only in rounding step, pool size or one byte of shared memory give different admitted counts, so each rounding rule and each pool selection is told apart. Oversized configurations (thread count, raw register product, shared memory, zero threads) must raise the never-fits flag and admit nothing. Directed sequences cover release followed by re-admission, simultaneous admit and release, a reconfiguration attempt while blocks are resident, and a completion pulse on an empty multiprocessor.

// File: rtl/blk_admit_pkg.sv
// Shared definitions for the thread-block admission controller.
// Assumes: the four pools are indexed in a fixed order by the gate.
package blk_admit_pkg;

    localparam int NUM_RES  = 4;
    localparam int FIT_BLK  = 0;
    localparam int FIT_WARP = 1;
    localparam int FIT_REG  = 2;
    localparam int FIT_SMEM = 3;

    // Register pool size select: base size, twice, four times.
    typedef enum logic [1:0] {
        POOL_X1  = 2'd0,
        POOL_X2  = 2'd1,
        POOL_X4  = 2'd2,
        POOL_X4B = 2'd3
    } reg_pool_e;

endpackage

// File: rtl/blk_admit_demand.sv
// Holds the launch configuration and derives one block's rounded demand on
// the warp, register and shared-memory pools, plus the never-fits flag.
// Assumes: WARP_SIZE and SMEM_GRAN are powers of two; register rounding
// steps are 4 and 8; the configuration only changes while no block is resident.
module blk_admit_demand
    import blk_admit_pkg::*;
#(
    parameter int WARP_SIZE       = 32,
    parameter int MAX_BLK_THREADS = 1024,
    parameter int MAX_WARPS       = 48,
    parameter int SMEM_POOL       = 49152,
    parameter int SMEM_GRAN       = 128,
    parameter int REG_POOL_MIN    = 8192,
    parameter int THR_W           = 11,
    parameter int RPT_W           = 8,
    parameter int SMEM_IN_W       = 17,
    parameter int WARP_W          = 6,
    parameter int REG_W           = 16,
    parameter int SMEM_W          = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic                 cfg_accept,
    input  logic [THR_W-1:0]     cfg_threads,
    input  logic [RPT_W-1:0]     cfg_rpt,
    input  logic [SMEM_IN_W-1:0] cfg_smem,
    input  logic [1:0]           cfg_pool_sel,
    input  logic                 cfg_gran8,
    output logic                 cfg_ok,
    output logic                 never_fits,
    output logic [WARP_W-1:0]    dem_warps,
    output logic [REG_W-1:0]     dem_regs,
    output logic [REG_W-1:0]     reg_limit,
    output logic [SMEM_W-1:0]    dem_smem
);
    localparam int WS_LG  = $clog2(WARP_SIZE);
    localparam int WF_W   = THR_W - WS_LG + 1;
    localparam int SLOT_W = WF_W + WS_LG;
    localparam int RR_W   = RPT_W + 1;
    localparam int BR_W   = RR_W + SLOT_W;
    localparam int RAW_W  = RPT_W + THR_W;
    localparam int SG_LG  = $clog2(SMEM_GRAN);
    localparam int SR_W   = SMEM_IN_W + 1;

    logic                 loaded_q;
    logic [THR_W-1:0]     thr_q;
    logic [RPT_W-1:0]     rpt_q;
    logic [SMEM_IN_W-1:0] smem_q;
    logic [1:0]           psel_q;
    logic                 gran8_q;

    logic [WF_W-1:0]   warps_full;
    logic [SLOT_W-1:0] slots;
    logic [RR_W-1:0]   rpt_r;
    logic [BR_W-1:0]   blk_regs;
    logic [RAW_W-1:0]  raw_regs;
    logic [SR_W-1:0]   smem_r;

    // Capture a new configuration only when the multiprocessor is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
            thr_q    <= '0;
            rpt_q    <= '0;
            smem_q   <= '0;
            psel_q   <= '0;
            gran8_q  <= 1'b0;
        end else if (cfg_load && cfg_accept) begin
            loaded_q <= 1'b1;
            thr_q    <= cfg_threads;
            rpt_q    <= cfg_rpt;
            smem_q   <= cfg_smem;
            psel_q   <= cfg_pool_sel;
            gran8_q  <= cfg_gran8;
        end
    end

    // Warps per block: thread count rounded up to whole warps.
    always_comb begin
        warps_full = WF_W'(thr_q[THR_W-1:WS_LG]) + WF_W'(|thr_q[WS_LG-1:0]);
        slots      = {warps_full, {WS_LG{1'b0}}};
    end

    // Registers per thread rounded up to the selected step of 4 or 8.
    always_comb begin
        if (gran8_q)
            rpt_r = {(RR_W-3)'(rpt_q[RPT_W-1:3]) + (RR_W-3)'(|rpt_q[2:0]), 3'b000};
        else
            rpt_r = {(RR_W-2)'(rpt_q[RPT_W-1:2]) + (RR_W-2)'(|rpt_q[1:0]), 2'b00};
    end

    // Register demand of one block, both rounded and as plainly requested.
    always_comb begin
        blk_regs = BR_W'(rpt_r) * BR_W'(slots);
        raw_regs = RAW_W'(rpt_q) * RAW_W'(thr_q);
    end

    // Shared memory rounded up to the allocation granule.
    always_comb begin
        smem_r = {(SR_W-SG_LG)'(smem_q[SMEM_IN_W-1:SG_LG]) + (SR_W-SG_LG)'(|smem_q[SG_LG-1:0]),
                  {SG_LG{1'b0}}};
    end

    // Register pool size from the select field.
    always_comb begin
        case (reg_pool_e'(psel_q))
            POOL_X1: reg_limit = REG_W'(REG_POOL_MIN);
            POOL_X2: reg_limit = REG_W'(REG_POOL_MIN * 2);
            default: reg_limit = REG_W'(REG_POOL_MIN * 4);
        endcase
    end

    // A block that exceeds any pool on an empty multiprocessor never fits.
    always_comb begin
        never_fits = loaded_q && ((thr_q == '0)
                                || (thr_q > THR_W'(MAX_BLK_THREADS))
                                || (warps_full > WF_W'(MAX_WARPS))
                                || (raw_regs > RAW_W'(reg_limit))
                                || (blk_regs > BR_W'(reg_limit))
                                || (smem_r > SR_W'(SMEM_POOL)));
        cfg_ok     = loaded_q && !never_fits;
    end

    // Demands sized to their pools; only meaningful while cfg_ok holds.
    always_comb begin
        dem_warps = warps_full[WARP_W-1:0];
        dem_regs  = blk_regs[REG_W-1:0];
        dem_smem  = smem_r[SMEM_W-1:0];
    end

endmodule

// File: rtl/blk_admit_pool.sv
// One resource pool: a running total of what resident blocks hold, and a
// fit test for one more block of the current demand.
// Assumes: take only when fits is high, give only when a block is held,
// and the demand is unchanged between a block's take and its give.
module blk_admit_pool #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] demand,
    input  logic         take,
    input  logic         give,
    output logic [W-1:0] used,
    output logic         fits
);
    logic [W:0] after_take;

    // Fit test against the total before this edge's changes.
    always_comb begin
        after_take = {1'b0, used} + {1'b0, demand};
        fits       = after_take <= {1'b0, limit};
    end

    // Running total: add on admit, subtract on release, both may coincide.
    always_ff @(posedge clk) begin
        if (!rst_n)
            used <= '0;
        else
            used <= used + (take ? demand : '0) - (give ? demand : '0);
    end

endmodule

// File: rtl/blk_admit_gate.sv
// Handshake and release control: raises ready when every pool fits,
// turns valid/ready into an admit strobe and a completion into a release.
// Assumes: occupied is high while at least one block is resident.
module blk_admit_gate #(
    parameter int NUM_RES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blk_valid,
    input  logic               blk_done,
    input  logic               cfg_ok,
    input  logic               occupied,
    input  logic [NUM_RES-1:0] fits,
    output logic               blk_ready,
    output logic               admit,
    output logic               free_blk,
    output logic               underflow
);
    // Admit at most one block per clock, only if all pools fit.
    always_comb begin
        blk_ready = cfg_ok && (&fits);
        admit     = blk_valid && blk_ready;
        free_blk  = blk_done && occupied;
    end

    // Sticky record of a completion with nothing resident.
    always_ff @(posedge clk) begin
        if (!rst_n)
            underflow <= 1'b0;
        else if (blk_done && !occupied)
            underflow <= 1'b1;
    end

endmodule

// File: rtl/blk_admit_ctrl.sv
// Thread-block admission controller for one multiprocessor. Holds a launch
// configuration, admits waiting blocks in order while four pools (block
// slots, warp slots, registers, shared memory) all fit, and returns one
// block's resources per completion pulse. Nothing is ever evicted.
// Assumes: one kernel's blocks share one configuration at a time.
module blk_admit_ctrl
    import blk_admit_pkg::*;
#(
    parameter int WARP_SIZE       = 32,
    parameter int MAX_BLOCKS      = 8,
    parameter int MAX_SM_THREADS  = 1536,
    parameter int MAX_BLK_THREADS = 1024,
    parameter int SMEM_POOL       = 49152,
    parameter int SMEM_GRAN       = 128,
    parameter int REG_POOL_MIN    = 8192,
    parameter int RPT_W           = 8,
    parameter int SMEM_IN_W       = 17,
    localparam int THR_W          = $clog2(MAX_BLK_THREADS) + 1,
    localparam int BLK_W          = $clog2(MAX_BLOCKS + 1),
    localparam int MAX_WARPS      = MAX_SM_THREADS / WARP_SIZE,
    localparam int WARP_W         = $clog2(MAX_WARPS + 1),
    localparam int REG_W          = $clog2(REG_POOL_MIN * 4 + 1),
    localparam int SMEM_W         = $clog2(SMEM_POOL + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [THR_W-1:0]     cfg_threads,
    input  logic [RPT_W-1:0]     cfg_regs_per_thread,
    input  logic [SMEM_IN_W-1:0] cfg_smem_bytes,
    input  logic [1:0]           cfg_reg_pool_sel,
    input  logic                 cfg_reg_gran8,
    input  logic                 blk_valid,
    output logic                 blk_ready,
    input  logic                 blk_done,
    output logic [BLK_W-1:0]     resident_blocks,
    output logic [WARP_W-1:0]    active_warps,
    output logic                 cfg_never_fits,
    output logic                 done_underflow
);
    logic               cfg_ok;
    logic               occupied;
    logic               admit;
    logic               free_blk;
    logic [NUM_RES-1:0] fits;
    logic [WARP_W-1:0]  dem_warps;
    logic [REG_W-1:0]   dem_regs;
    logic [REG_W-1:0]   reg_limit;
    logic [SMEM_W-1:0]  dem_smem;
    logic [BLK_W-1:0]   blk_used;
    logic [WARP_W-1:0]  warp_used;
    logic [REG_W-1:0]   reg_used;
    logic [SMEM_W-1:0]  smem_used;

    blk_admit_demand #(
        .WARP_SIZE      (WARP_SIZE),
        .MAX_BLK_THREADS(MAX_BLK_THREADS),
        .MAX_WARPS      (MAX_WARPS),
        .SMEM_POOL      (SMEM_POOL),
        .SMEM_GRAN      (SMEM_GRAN),
        .REG_POOL_MIN   (REG_POOL_MIN),
        .THR_W          (THR_W),
        .RPT_W          (RPT_W),
        .SMEM_IN_W      (SMEM_IN_W),
        .WARP_W         (WARP_W),
        .REG_W          (REG_W),
        .SMEM_W         (SMEM_W)
    ) u_demand (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_load    (cfg_load),
        .cfg_accept  (!occupied),
        .cfg_threads (cfg_threads),
        .cfg_rpt     (cfg_regs_per_thread),
        .cfg_smem    (cfg_smem_bytes),
        .cfg_pool_sel(cfg_reg_pool_sel),
        .cfg_gran8   (cfg_reg_gran8),
        .cfg_ok      (cfg_ok),
        .never_fits  (cfg_never_fits),
        .dem_warps   (dem_warps),
        .dem_regs    (dem_regs),
        .reg_limit   (reg_limit),
        .dem_smem    (dem_smem)
    );

    // Resident block slots.
    blk_admit_pool #(.W(BLK_W)) u_pool_blk (
        .clk(clk), .rst_n(rst_n),
        .limit(BLK_W'(MAX_BLOCKS)), .demand(BLK_W'(1)),
        .take(admit), .give(free_blk),
        .used(blk_used), .fits(fits[FIT_BLK])
    );

    // Warp slots (threads in whole warps).
    blk_admit_pool #(.W(WARP_W)) u_pool_warp (
        .clk(clk), .rst_n(rst_n),
        .limit(WARP_W'(MAX_WARPS)), .demand(dem_warps),
        .take(admit), .give(free_blk),
        .used(warp_used), .fits(fits[FIT_WARP])
    );

    // Register file.
    blk_admit_pool #(.W(REG_W)) u_pool_reg (
        .clk(clk), .rst_n(rst_n),
        .limit(reg_limit), .demand(dem_regs),
        .take(admit), .give(free_blk),
        .used(reg_used), .fits(fits[FIT_REG])
    );

    // Shared memory.
    blk_admit_pool #(.W(SMEM_W)) u_pool_smem (
        .clk(clk), .rst_n(rst_n),
        .limit(SMEM_W'(SMEM_POOL)), .demand(dem_smem),
        .take(admit), .give(free_blk),
        .used(smem_used), .fits(fits[FIT_SMEM])
    );

    blk_admit_gate #(.NUM_RES(NUM_RES)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_valid(blk_valid),
        .blk_done (blk_done),
        .cfg_ok   (cfg_ok),
        .occupied (occupied),
        .fits     (fits),
        .blk_ready(blk_ready),
        .admit    (admit),
        .free_blk (free_blk),
        .underflow(done_underflow)
    );

    // Status outputs straight from the block and warp totals.
    always_comb begin
        occupied        = blk_used != '0;
        resident_blocks = blk_used;
        active_warps    = warp_used;
    end

endmodule

// File: rtl/blk_admit_checker.sv
// Assertion checker for the admission controller, bound to the top module.
// Assumes: the bind reaches the top's internal pool totals by name.
module blk_admit_checker #(
    parameter int MAX_BLOCKS = 8,
    parameter int MAX_WARPS  = 48,
    parameter int SMEM_POOL  = 49152,
    parameter int BLK_W      = 4,
    parameter int WARP_W     = 6,
    parameter int REG_W      = 16,
    parameter int SMEM_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic              blk_valid,
    input logic              blk_ready,
    input logic              blk_done,
    input logic [BLK_W-1:0]  resident_blocks,
    input logic [WARP_W-1:0] active_warps,
    input logic              cfg_never_fits,
    input logic              done_underflow,
    input logic [REG_W-1:0]  reg_used,
    input logic [REG_W-1:0]  reg_limit,
    input logic [SMEM_W-1:0] smem_used,
    input logic [WARP_W-1:0] dem_warps
);
    logic admit_c;
    logic free_c;

    // Handshake events as seen at the ports.
    always_comb begin
        admit_c = blk_valid && blk_ready;
        free_c  = blk_done && (resident_blocks != '0);
    end

    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && resident_blocks != '0) |=> $stable(dem_warps));

    assert_block_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resident_blocks <= BLK_W'(MAX_BLOCKS));

    assert_warp_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active_warps <= WARP_W'(MAX_WARPS));

    assert_smem_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smem_used <= SMEM_W'(SMEM_POOL));

    assert_reg_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_used <= reg_limit);

    assert_no_ready_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_never_fits |-> !blk_ready);

    assert_admit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (admit_c && !free_c) |=> resident_blocks == $past(resident_blocks) + BLK_W'(1));

    assert_release_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (free_c && !admit_c) |=> resident_blocks == $past(resident_blocks) - BLK_W'(1));

    assert_warps_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!admit_c && !free_c) |=> $stable(active_warps));

    assert_underflow_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && resident_blocks == '0) |=> done_underflow);

    assert_underflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_underflow |=> done_underflow);

endmodule

bind blk_admit_ctrl blk_admit_checker #(
    .MAX_BLOCKS(MAX_BLOCKS),
    .MAX_WARPS (MAX_WARPS),
    .SMEM_POOL (SMEM_POOL),
    .BLK_W     (BLK_W),
    .WARP_W    (WARP_W),
    .REG_W     (REG_W),
    .SMEM_W    (SMEM_W)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_load       (cfg_load),
    .blk_valid      (blk_valid),
    .blk_ready      (blk_ready),
    .blk_done       (blk_done),
    .resident_blocks(resident_blocks),
    .active_warps   (active_warps),
    .cfg_never_fits (cfg_never_fits),
    .done_underflow (done_underflow),
    .reg_used       (reg_used),
    .reg_limit      (reg_limit),
    .smem_used      (smem_used),
    .dem_warps      (dem_warps)
);

// File: tb/sim_blk_admit_ctrl.sv
// Bench for the admission controller: a vector table of configurations with
// their expected admitted counts, then directed sequences.
module sim_blk_admit_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    typedef struct packed {
        logic [10:0] thr;
        logic [7:0]  rpt;
        logic [16:0] smem;
        logic [1:0]  psel;
        logic        g8;
        logic [3:0]  n;
        logic        err;
    } vec_t;

    // threads, regs/thread, smem, pool sel, step8, expected resident, never-fits
    localparam vec_t VECS [NVEC] = '{
        '{11'd1,    8'd1,  17'd1,     2'd0, 1'b0, 4'd8, 1'b0}, // R3 block cap
        '{11'd50,   8'd16, 17'd0,     2'd2, 1'b0, 4'd8, 1'b0}, // R4 2 warps each
        '{11'd256,  8'd17, 17'd0,     2'd2, 1'b1, 4'd5, 1'b0}, // R6 step 8 -> 24
        '{11'd256,  8'd17, 17'd0,     2'd2, 1'b0, 4'd6, 1'b0}, // R6 step 4 -> 20
        '{11'd32,   8'd4,  17'd6145,  2'd2, 1'b0, 4'd7, 1'b0}, // R5 rounds to 6272
        '{11'd32,   8'd4,  17'd6144,  2'd2, 1'b0, 4'd8, 1'b0}, // R5 exact granule
        '{11'd1024, 8'd8,  17'd0,     2'd2, 1'b0, 4'd1, 1'b0}, // R4 large block
        '{11'd256,  8'd8,  17'd0,     2'd0, 1'b0, 4'd4, 1'b0}, // R6 pool 8192
        '{11'd256,  8'd12, 17'd0,     2'd1, 1'b0, 4'd5, 1'b0}, // R6 pool 16384
        '{11'd1025, 8'd1,  17'd0,     2'd2, 1'b0, 4'd0, 1'b1}, // R7 too many threads
        '{11'd1024, 8'd33, 17'd0,     2'd2, 1'b0, 4'd0, 1'b1}, // R7 raw regs > pool
        '{11'd32,   8'd1,  17'd49153, 2'd2, 1'b0, 4'd0, 1'b1}, // R7 smem > pool
        '{11'd0,    8'd1,  17'd0,     2'd2, 1'b0, 4'd0, 1'b1}, // R7 zero threads
        '{11'd1000, 8'd8,  17'd0,     2'd0, 1'b0, 4'd1, 1'b0}  // R6 exact register fit
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [10:0] cfg_threads = '0;
    logic [7:0]  cfg_regs_per_thread = '0;
    logic [16:0] cfg_smem_bytes = '0;
    logic [1:0]  cfg_reg_pool_sel = '0;
    logic        cfg_reg_gran8 = 1'b0;
    logic        blk_valid = 1'b0;
    logic        blk_ready;
    logic        blk_done = 1'b0;
    logic [3:0]  resident_blocks;
    logic [5:0]  active_warps;
    logic        cfg_never_fits;
    logic        done_underflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    blk_admit_ctrl u0 (
        .clk                (clk),
        .rst_n              (rst_n),
        .cfg_load           (cfg_load),
        .cfg_threads        (cfg_threads),
        .cfg_regs_per_thread(cfg_regs_per_thread),
        .cfg_smem_bytes     (cfg_smem_bytes),
        .cfg_reg_pool_sel   (cfg_reg_pool_sel),
        .cfg_reg_gran8      (cfg_reg_gran8),
        .blk_valid          (blk_valid),
        .blk_ready          (blk_ready),
        .blk_done           (blk_done),
        .resident_blocks    (resident_blocks),
        .active_warps       (active_warps),
        .cfg_never_fits     (cfg_never_fits),
        .done_underflow     (done_underflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        blk_valid = 1'b0;
        blk_done  = 1'b0;
        cfg_load  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_cfg(input int thr, input int rpt, input int smem,
                            input int psel, input bit g8);
        cfg_threads         = 11'(thr);
        cfg_regs_per_thread = 8'(rpt);
        cfg_smem_bytes      = 17'(smem);
        cfg_reg_pool_sel    = 2'(psel);
        cfg_reg_gran8       = g8;
        cfg_load            = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 resident after reset", int'(resident_blocks), 0);
        check("R1 warps after reset", int'(active_warps), 0);
        check("R1 ready without config", int'(blk_ready), 0);
        check("R1 never-fits after reset", int'(cfg_never_fits), 0);
        check("R1 underflow after reset", int'(done_underflow), 0);

        // Table walk: offer blocks continuously and count admissions.
        for (int v = 0; v < NVEC; v++) begin
            int cnt;
            int wpb;
            do_reset();
            load_cfg(int'(VECS[v].thr), int'(VECS[v].rpt), int'(VECS[v].smem),
                     int'(VECS[v].psel), VECS[v].g8);
            blk_valid = 1'b1;
            cnt = 0;
            for (int c = 0; c < 12; c++) begin
                if (blk_ready) cnt++;
                @(negedge clk);
            end
            blk_valid = 1'b0;
            wpb = (int'(VECS[v].thr) + 31) / 32;
            check($sformatf("R8 vec %0d admitted count", v), cnt, int'(VECS[v].n));
            check($sformatf("R3 R4 R5 R6 vec %0d resident limit", v),
                  int'(resident_blocks), int'(VECS[v].n));
            check($sformatf("R10 vec %0d active warps", v),
                  int'(active_warps), int'(VECS[v].n) * wpb);
            check($sformatf("R7 vec %0d never-fits flag", v),
                  int'(cfg_never_fits), int'(VECS[v].err));
        end

        // R9/R10: release then re-admit of a waiting block.
        do_reset();
        load_cfg(1024, 8, 0, 2, 1'b0);
        blk_valid = 1'b1;
        @(negedge clk);
        check("R8 one block admitted", int'(resident_blocks), 1);
        check("R8 second block waits", int'(blk_ready), 0);
        check("R10 warps after admit", int'(active_warps), 32);
        blk_done = 1'b1;
        @(negedge clk);
        blk_done = 1'b0;
        check("R9 resident after release", int'(resident_blocks), 0);
        check("R10 warps after release", int'(active_warps), 0);
        check("R9 ready after release", int'(blk_ready), 1);
        @(negedge clk);
        blk_valid = 1'b0;
        check("R9 waiting block re-admitted", int'(resident_blocks), 1);
        check("R10 warps after re-admit", int'(active_warps), 32);

        // R8/R9: one per clock, then admit and release on the same edge.
        do_reset();
        load_cfg(32, 4, 0, 2, 1'b0);
        blk_valid = 1'b1;
        @(negedge clk);
        check("R8 one admit per clock", int'(resident_blocks), 1);
        repeat (2) @(negedge clk);
        blk_valid = 1'b0;
        check("R8 three admits", int'(resident_blocks), 3);
        blk_valid = 1'b1;
        blk_done  = 1'b1;
        @(negedge clk);
        blk_valid = 1'b0;
        blk_done  = 1'b0;
        check("R9 admit plus release keeps resident", int'(resident_blocks), 3);
        check("R9 admit plus release keeps warps", int'(active_warps), 3);

        // R2: reconfiguration while resident is ignored.
        do_reset();
        load_cfg(50, 16, 0, 2, 1'b0);
        blk_valid = 1'b1;
        @(negedge clk);
        blk_valid = 1'b0;
        check("R2 first block warps", int'(active_warps), 2);
        load_cfg(1024, 8, 0, 2, 1'b0);
        blk_valid = 1'b1;
        @(negedge clk);
        blk_valid = 1'b0;
        check("R2 resident after ignored load", int'(resident_blocks), 2);
        check("R2 warps use old config", int'(active_warps), 4);

        // R11: completion with nothing resident.
        do_reset();
        blk_done = 1'b1;
        @(negedge clk);
        blk_done = 1'b0;
        check("R11 underflow set", int'(done_underflow), 1);
        check("R11 resident unchanged", int'(resident_blocks), 0);
        check("R11 warps unchanged", int'(active_warps), 0);
        load_cfg(32, 4, 0, 2, 1'b0);
        blk_valid = 1'b1;
        @(negedge clk);
        blk_valid = 1'b0;
        blk_done  = 1'b1;
        @(negedge clk);
        blk_done = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 underflow sticky", int'(done_underflow), 1);
        check("R9 release after underflow", int'(resident_blocks), 0);
        do_reset();
        check("R11 underflow cleared by reset", int'(done_underflow), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule